// File: doc/BRIEF.md
# Dual-Copy Checkpointed Register File

This block is an architectural register file that can be returned to its value at the last basic-block boundary at low cost. It keeps two full physical copies of every register and a per-register bank-select bit. The first write to a register inside a basic block flips that register's select bit and puts the new value in the other copy. The value committed at the last block boundary therefore stays intact in the copy it was already in. Later writes to the same register in the same block go to the copy already selected. A dirty mask records which registers the running block has touched.

A block-end pulse commits the current selection as the new checkpoint and clears the dirty mask. A rollback pulse puts the selection back to the checkpoint taken at the last block end and clears the dirty mask. The surrounding pipeline can then restart the block in instruction-precise mode. The selection masks sit in a small ring with one slot per in-flight basic block plus one.

All ports are plain control and data pins. Reads are combinational. A write takes effect at the clock edge and has no handshake: the register file accepts a write in every cycle, so there is no back-pressure.

Top module: `ckrf_top`

## Requirements
- R1: After reset every register reads 0 on every read port.
- R2: A read returns the most recent value written to that register. A read in the same cycle as a write to the same register returns the value from before the write.
- R3: The first write to a register inside a block leaves the value committed at the last block end recoverable: a rollback returns the register to that value.
- R4: When a register is written several times in one block, reads return the last write. A rollback still returns the value from the start of the block.
- R5: After a block end, a rollback returns the values held at that block end, including the writes made in the ended block.
- R6: A rollback restores every register to its value at the last block end (0 if no block has ended since reset) and clears the dirty state, so the next block records and restores its own writes correctly.
- R7: A write in the same cycle as a rollback has no effect. The register reads its checkpoint value afterwards.
- R8: When block end and rollback are asserted in the same cycle, the rollback takes effect and the block end is ignored.
- R9: A write in the same cycle as a block end belongs to the ending block, so it survives a later rollback.
- R10: Registers that are not written are unaffected by writes, block ends and rollbacks of other registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Register to write |
| wr_data | input | DW | Value to write |
| block_end | input | 1 | Commit the current mapping as the new checkpoint |
| rollback | input | 1 | Restore the mapping from the last checkpoint |
| rd_addr | input | NRD*AW | Packed read addresses, port 0 in the low bits |
| rd_data | output | NRD*DW | Packed read data, port 0 in the low bits |

## Verification
A write can fall in the same cycle as a block end, in the same cycle as a rollback, or in the same cycle as a block end and a rollback together. A read can also coincide with a write to the same register. The bench drives each of these pairings on purpose with a single pulse. It then reads every register through both read ports and compares the result with a reference model. The model applies the write before the commit, drops the write on a rollback, and lets a rollback override a block end. A long sweep mixes these pairings over many blocks of arithmetic write patterns.

// File: rtl/ckrf_pkg.sv
package ckrf_pkg;
  parameter int CKRF_NREGS    = 16;
  parameter int CKRF_DW       = 32;
  parameter int CKRF_NRD      = 2;
  parameter int CKRF_INFLIGHT = 1;

  function automatic int ring_ptr_w(input int slots);
    return (slots > 1) ? $clog2(slots) : 1;
  endfunction
endpackage

// File: rtl/ckrf_bank.sv
module ckrf_bank #(
  parameter int NREGS = ckrf_pkg::CKRF_NREGS,
  parameter int DW    = ckrf_pkg::CKRF_DW,
  parameter int NRD   = ckrf_pkg::CKRF_NRD,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [NRD*AW-1:0] raddr,
  output logic [NRD*DW-1:0] rdata
);
  logic [DW-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p*DW +: DW] = mem[raddr[p*AW +: AW]];
  end
endmodule

// File: rtl/ckrf_map.sv
module ckrf_map #(
  parameter int NREGS    = ckrf_pkg::CKRF_NREGS,
  parameter int INFLIGHT = ckrf_pkg::CKRF_INFLIGHT,
  localparam int AW      = $clog2(NREGS),
  localparam int NSLOT   = INFLIGHT + 1,
  localparam int PW      = ckrf_pkg::ring_ptr_w(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic             block_end,
  input  logic             rollback,
  output logic [NREGS-1:0] active_mask,
  output logic [NREGS-1:0] ckpt_mask,
  output logic             wr_sel
);
  logic [NREGS-1:0] slot [NSLOT];
  logic [NREGS-1:0] dirty;
  logic [PW-1:0]    ptr, ptr_nx, ptr_pv;
  logic [NREGS-1:0] act_nx;
  logic             first_wr;

  assign ptr_nx = (ptr == PW'(NSLOT-1)) ? '0 : ptr + 1'b1;
  assign ptr_pv = (ptr == '0) ? PW'(NSLOT-1) : ptr - 1'b1;

  assign active_mask = slot[ptr];
  assign ckpt_mask   = slot[ptr_pv];
  assign first_wr    = wr_en && !dirty[wr_addr];
  assign wr_sel      = first_wr ? ~active_mask[wr_addr] : active_mask[wr_addr];

  always_comb begin
    act_nx = active_mask;
    if (first_wr) act_nx[wr_addr] = ~active_mask[wr_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) slot[i] <= '0;
      dirty <= '0;
      ptr   <= '0;
    end else if (rollback) begin
      slot[ptr] <= slot[ptr_pv];
      dirty     <= '0;
    end else if (block_end) begin
      slot[ptr]    <= act_nx;
      slot[ptr_nx] <= act_nx;
      ptr          <= ptr_nx;
      dirty        <= '0;
    end else begin
      slot[ptr] <= act_nx;
      if (wr_en) dirty[wr_addr] <= 1'b1;
    end
  end

  p_dirty_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (block_end || rollback) |=> (dirty == '0));

  p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rollback |=> (active_mask == $past(ckpt_mask)));

  p_first_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rollback && !dirty[wr_addr])
      |=> (active_mask[$past(wr_addr)] != $past(active_mask[wr_addr])));

  p_later_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rollback && !block_end && dirty[wr_addr])
      |=> $stable(active_mask));

  p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (block_end && !rollback) |=> (ckpt_mask == active_mask));
endmodule

// File: rtl/ckrf_top.sv
module ckrf_top #(
  parameter int NREGS    = ckrf_pkg::CKRF_NREGS,
  parameter int DW       = ckrf_pkg::CKRF_DW,
  parameter int NRD      = ckrf_pkg::CKRF_NRD,
  parameter int INFLIGHT = ckrf_pkg::CKRF_INFLIGHT,
  localparam int AW      = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              block_end,
  input  logic              rollback,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic [NRD*DW-1:0] rd_data
);
  logic [NREGS-1:0]  active_mask, ckpt_mask;
  logic              wr_sel;
  logic [NRD*DW-1:0] bank_rd [2];

  ckrf_map #(.NREGS(NREGS), .INFLIGHT(INFLIGHT)) u_map (
    .clk, .rst_n, .wr_en, .wr_addr, .block_end, .rollback,
    .active_mask, .ckpt_mask, .wr_sel
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ckrf_bank #(.NREGS(NREGS), .DW(DW), .NRD(NRD)) u_bank (
      .clk, .rst_n,
      .we    (wr_en && (wr_sel == 1'(b))),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rdata (bank_rd[b])
    );
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rsel
    logic [AW-1:0] ra;
    assign ra = rd_addr[p*AW +: AW];
    assign rd_data[p*DW +: DW] = active_mask[ra] ? bank_rd[1][p*DW +: DW]
                                                 : bank_rd[0][p*DW +: DW];
  end

  p_untouched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rollback) |=> $stable(active_mask));

  p_wr_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rollback) |=> (active_mask == $past(ckpt_mask)));
endmodule

// File: tb/ckrf_top_bench.sv
`timescale 1ns/1ps
module ckrf_top_bench;
  localparam int NREGS = 16;
  localparam int DW    = 32;
  localparam int NRD   = 2;
  localparam int AW    = $clog2(NREGS);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [DW-1:0]     wr_data = '0;
  logic              block_end = 1'b0;
  logic              rollback = 1'b0;
  logic [NRD*AW-1:0] rd_addr = '0;
  logic [NRD*DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] cur  [NREGS];
  logic [DW-1:0] ckpt [NREGS];

  always #4 clk = ~clk;

  ckrf_top #(.NREGS(NREGS), .DW(DW), .NRD(NRD)) u_ckrf_top (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .block_end, .rollback,
    .rd_addr, .rd_data
  );

  function automatic logic [DW-1:0] pat(input int r, input int k);
    return DW'((r + 1) * 32'h0101_0101) ^ DW'(k * 32'h9E37_79B1) ^ DW'(k << 4);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int r = 0; r < NREGS; r++) begin
      rd_addr[0 +: AW]  = AW'(r);
      rd_addr[AW +: AW] = AW'(NREGS - 1 - r);
      #0.2;
      chk(req, rd_data[0 +: DW], cur[r]);
      chk(req, rd_data[DW +: DW], cur[NREGS - 1 - r]);
    end
  endtask

  task automatic step(input bit we, input int a, input logic [DW-1:0] d,
                      input bit be, input bit rb);
    @(negedge clk);
    wr_en = we; wr_addr = AW'(a); wr_data = d; block_end = be; rollback = rb;
    @(posedge clk);
    if (rb) begin
      for (int i = 0; i < NREGS; i++) cur[i] = ckpt[i];
    end else begin
      if (we) cur[a] = d;
      if (be) for (int i = 0; i < NREGS; i++) ckpt[i] = cur[i];
    end
    @(negedge clk);
    wr_en = 1'b0; block_end = 1'b0; rollback = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NREGS; i++) begin cur[i] = '0; ckpt[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check_all("R1");

    // R2: first block writes every register, then commits (R5)
    for (int r = 0; r < NREGS; r++) step(1, r, pat(r, 1), 0, 0);
    check_all("R2");
    step(0, 0, '0, 1, 0);
    check_all("R5");

    // R4: even registers written twice, odd untouched (R10)
    for (int r = 0; r < NREGS; r += 2) step(1, r, pat(r, 2), 0, 0);
    for (int r = 0; r < NREGS; r += 2) step(1, r, pat(r, 3), 0, 0);
    check_all("R4");
    step(0, 0, '0, 0, 1);
    check_all("R3 R6 R10");

    // R6: dirty cleared, next block restored correctly
    step(1, 4, pat(4, 5), 0, 0);
    step(0, 0, '0, 0, 1);
    check_all("R6");

    // R7: write with rollback is dropped
    step(1, 9, pat(9, 7), 0, 1);
    check_all("R7");

    // R9: write on block end belongs to ending block
    step(1, 3, pat(3, 8), 0, 0);
    step(1, 5, pat(5, 8), 1, 0);
    step(0, 0, '0, 0, 1);
    check_all("R9");

    // R8: block end and rollback together, rollback wins
    step(1, 7, pat(7, 9), 0, 0);
    step(0, 0, '0, 1, 1);
    check_all("R8");

    // R2: same-cycle read of a register being written returns the old value
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(11); wr_data = pat(11, 10);
    rd_addr[0 +: AW] = AW'(11);
    #0.2;
    chk("R2", rd_data[0 +: DW], cur[11]);
    @(posedge clk); cur[11] = pat(11, 10);
    @(negedge clk); wr_en = 1'b0;
    #0.2;
    chk("R2", rd_data[0 +: DW], cur[11]);

    // sweep of mixed blocks
    for (int k = 20; k < 80; k++) begin
      for (int j = 0; j < 1 + (k % 5); j++)
        step(1, (k * 3 + j * 5) % NREGS, pat(j, k), 0, 0);
      case (k % 4)
        0: step(0, 0, '0, 1, 0);
        1: step(0, 0, '0, 0, 1);
        2: step(1, k % NREGS, pat(k, k), 1, 0);
        default: step(1, (k + 1) % NREGS, pat(k, 1), k[3], 1);
      endcase
      check_all((k % 4 == 1) ? "R6" : (k % 4 == 2) ? "R9" : (k % 4 == 3) ? "R7" : "R5");
    end

    finish_run();
  end
endmodule